// File: doc/BRIEF.md
# Clock Start-up Delay Sequencer

This block keeps the core in a not-ready state after a wake-up from a sleep mode or after a reset, until the newly selected clock source can be trusted. A one-cycle request on `boot_req` (reset) or `wake_req` (wake from power-down or power-save) starts a delay. The delay's length is chosen by the clock source class (`src_slow`: 0 for the fast PLL-derived clock, 1 for the low-power 128 kHz oscillator) and by a 2-bit start-up select code `sut_code`. The source class and code are captured on the request edge.

A wake delay is a pure count of clock cycles. A reset delay first counts a fixed number of clock cycles. It then counts a millisecond portion on the slow `ms_tick` input, where `TICKS_PER_MS` ticks make one millisecond. `ready` goes high when the whole delay has elapsed. `code_err` marks a reserved code; the block then uses the longest valid delay for that source.

All pins are plain control and status levels or pulses. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `clk_startup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until a request completes its delay, `ready` and `code_err` are 0.
- R2: With `src_slow`=0, a wake request makes `ready` rise exactly 1024 clock edges after the request edge for codes 0 and 2, and exactly 16384 edges after it for codes 1 and 3.
- R3: With `src_slow`=0, a reset request counts 14 clock edges and then 8 ms (codes 0 and 1) or 68 ms (codes 2 and 3), measured as ms × `TICKS_PER_MS` ticks.
- R4: With `src_slow`=1, a wake request makes `ready` rise exactly 6 clock edges after the request edge for codes 0, 1 and 2.
- R5: With `src_slow`=1, a reset request counts 14 clock edges and then 0 ms (code 0), 4 ms (code 1) or 64 ms (code 2).
- R6: With `src_slow`=1, code 3 is reserved. `code_err` is 1 from the edge after such a request until the next request with a valid combination. The delay used is that of code 2.
- R7: `ready` is 0 from the edge after any request until the delay completes. It rises on the edge where the last cycle or tick is counted, and then holds until the next request.
- R8: The cycle portion runs first. A tick counts only when it is sampled high on an edge after the cycle portion has ended, and ticks seen during the cycle portion are ignored.
- R9: A request arriving during a delay restarts the delay from zero with the newly sampled configuration. If both request inputs are high on the same edge, the reset request wins.
- R10: Changes on `src_slow` and `sut_code` between requests affect neither the delay in progress nor `code_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the newly started source |
| rst_n | input | 1 | Asynchronous active-low block reset |
| boot_req | input | 1 | One-cycle pulse: a reset event occurred |
| wake_req | input | 1 | One-cycle pulse: wake from power-down or power-save |
| src_slow | input | 1 | Clock source class: 0 PLL-derived, 1 128 kHz oscillator |
| sut_code | input | 2 | Start-up select code |
| ms_tick | input | 1 | Slow time base, one-cycle pulse, `TICKS_PER_MS` per millisecond |
| ready | output | 1 | High once the selected delay has elapsed |
| code_err | output | 1 | Reserved code seen at the last request |

## Verification
The assertions assume that `ms_tick` is synchronous to `clk` and that the configuration that matters is the one present on the request edge. They also assume that every delay is at least six cycles long. The stimulus pulses `ms_tick` on every third edge. It scrambles `src_slow` and `sut_code` on every edge between requests. Random requests keep the fast-source wake at its short length, so that each run stays short, and the long fast wakes are covered by directed runs.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CYC  = 2'd1,
    PH_MS   = 2'd2,
    PH_DONE = 2'd3
  } seq_phase_e;

  localparam logic [1:0] CODE_RESERVED = 2'd3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sus_delay_lut.sv
module sus_delay_lut
  import clk_seq_pkg::*;
#(
  parameter int FAST_WAKE_SHORT = 1024,
  parameter int FAST_WAKE_LONG  = 16384,
  parameter int SLOW_WAKE       = 6,
  parameter int RESET_CYC       = 14,
  parameter int FAST_MS_SHORT   = 8,
  parameter int FAST_MS_LONG    = 68,
  parameter int SLOW_MS_MID     = 4,
  parameter int SLOW_MS_LONG    = 64,
  parameter int TICKS_PER_MS    = 8,
  parameter int CYC_W           = 15,
  parameter int TICK_W          = 10
) (
  input  logic              src_slow,
  input  logic [1:0]        code,
  input  logic              for_reset,
  output logic [CYC_W-1:0]  cyc_tgt,
  output logic [TICK_W-1:0] tick_tgt,
  output logic              reserved
);

  int unsigned ms_val;
  logic [1:0]  eff_code;

  always_comb begin
    reserved = src_slow && (code == CODE_RESERVED);
    eff_code = reserved ? 2'd2 : code;
  end

  always_comb begin
    ms_val  = 0;
    cyc_tgt = CYC_W'(RESET_CYC);
    if (for_reset) begin
      cyc_tgt = CYC_W'(RESET_CYC);
      if (!src_slow) begin
        ms_val = eff_code[1] ? FAST_MS_LONG : FAST_MS_SHORT;
      end else begin
        case (eff_code)
          2'd0:    ms_val = 0;
          2'd1:    ms_val = SLOW_MS_MID;
          default: ms_val = SLOW_MS_LONG;
        endcase
      end
    end else begin
      if (!src_slow) begin
        cyc_tgt = eff_code[0] ? CYC_W'(FAST_WAKE_LONG) : CYC_W'(FAST_WAKE_SHORT);
      end else begin
        cyc_tgt = CYC_W'(SLOW_WAKE);
      end
    end
    tick_tgt = TICK_W'(ms_val * TICKS_PER_MS);
  end

endmodule

// File: rtl/sus_up_cnt.sv
module sus_up_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/sus_phase_ctl.sv
module sus_phase_ctl
  import clk_seq_pkg::*;
#(
  parameter int CYC_W  = 15,
  parameter int TICK_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CYC_W-1:0]  cyc_tgt_in,
  input  logic [TICK_W-1:0] tick_tgt_in,
  input  logic              reserved_in,
  input  logic [CYC_W-1:0]  cyc_cnt,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic              tick,
  output seq_phase_e        phase,
  output logic              ready,
  output logic              code_err
);

  seq_phase_e        phase_d;
  logic [CYC_W-1:0]  cyc_tgt_q;
  logic [TICK_W-1:0] tick_tgt_q;
  logic              cyc_last;
  logic              tick_last;
  logic              no_ms;

  always_comb begin
    cyc_last  = (cyc_cnt == (cyc_tgt_q - CYC_W'(1)));
    tick_last = tick && (tick_cnt == (tick_tgt_q - TICK_W'(1)));
    no_ms     = (tick_tgt_q == '0);
  end

  always_comb begin
    phase_d = phase;
    if (req) begin
      phase_d = PH_CYC;
    end else begin
      case (phase)
        PH_CYC:  if (cyc_last) phase_d = no_ms ? PH_DONE : PH_MS;
        PH_MS:   if (tick_last) phase_d = PH_DONE;
        default: phase_d = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cyc_tgt_q  <= '0;
      tick_tgt_q <= '0;
      code_err   <= 1'b0;
      ready      <= 1'b0;
    end else begin
      phase <= phase_d;
      ready <= (phase_d == PH_DONE);
      if (req) begin
        cyc_tgt_q  <= cyc_tgt_in;
        tick_tgt_q <= tick_tgt_in;
        code_err   <= reserved_in;
      end
    end
  end

endmodule

// File: rtl/clk_startup_seq.sv
module clk_startup_seq
  import clk_seq_pkg::*;
#(
  parameter int FAST_WAKE_SHORT = 1024,
  parameter int FAST_WAKE_LONG  = 16384,
  parameter int SLOW_WAKE       = 6,
  parameter int RESET_CYC       = 14,
  parameter int FAST_MS_SHORT   = 8,
  parameter int FAST_MS_LONG    = 68,
  parameter int SLOW_MS_MID     = 4,
  parameter int SLOW_MS_LONG    = 64,
  parameter int TICKS_PER_MS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_req,
  input  logic       wake_req,
  input  logic       src_slow,
  input  logic [1:0] sut_code,
  input  logic       ms_tick,
  output logic       ready,
  output logic       code_err
);

  localparam int CYC_MAX  = imax(imax(FAST_WAKE_SHORT, FAST_WAKE_LONG),
                                 imax(SLOW_WAKE, RESET_CYC));
  localparam int MS_MAX   = imax(imax(FAST_MS_SHORT, FAST_MS_LONG),
                                 imax(SLOW_MS_MID, SLOW_MS_LONG));
  localparam int CYC_W    = bits_for(CYC_MAX);
  localparam int TICK_W   = bits_for(MS_MAX * TICKS_PER_MS);

  logic              req;
  logic [CYC_W-1:0]  lut_cyc;
  logic [TICK_W-1:0] lut_tick;
  logic              lut_reserved;
  logic [CYC_W-1:0]  cyc_cnt;
  logic [TICK_W-1:0] tick_cnt;
  seq_phase_e        phase;

  assign req = boot_req | wake_req;

  sus_delay_lut #(
    .FAST_WAKE_SHORT (FAST_WAKE_SHORT),
    .FAST_WAKE_LONG  (FAST_WAKE_LONG),
    .SLOW_WAKE       (SLOW_WAKE),
    .RESET_CYC       (RESET_CYC),
    .FAST_MS_SHORT   (FAST_MS_SHORT),
    .FAST_MS_LONG    (FAST_MS_LONG),
    .SLOW_MS_MID     (SLOW_MS_MID),
    .SLOW_MS_LONG    (SLOW_MS_LONG),
    .TICKS_PER_MS    (TICKS_PER_MS),
    .CYC_W           (CYC_W),
    .TICK_W          (TICK_W)
  ) u_lut (
    .src_slow  (src_slow),
    .code      (sut_code),
    .for_reset (boot_req),
    .cyc_tgt   (lut_cyc),
    .tick_tgt  (lut_tick),
    .reserved  (lut_reserved)
  );

  sus_up_cnt #(.W(CYC_W)) u_cyc_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req),
    .inc   (phase == PH_CYC),
    .cnt   (cyc_cnt)
  );

  sus_up_cnt #(.W(TICK_W)) u_tick_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req),
    .inc   ((phase == PH_MS) && ms_tick),
    .cnt   (tick_cnt)
  );

  sus_phase_ctl #(
    .CYC_W  (CYC_W),
    .TICK_W (TICK_W)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .cyc_tgt_in  (lut_cyc),
    .tick_tgt_in (lut_tick),
    .reserved_in (lut_reserved),
    .cyc_cnt     (cyc_cnt),
    .tick_cnt    (tick_cnt),
    .tick        (ms_tick),
    .phase       (phase),
    .ready       (ready),
    .code_err    (code_err)
  );

endmodule

// File: rtl/clk_startup_seq_checker.sv
module clk_startup_seq_checker #(
  parameter int MIN_GAP = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       boot_req,
  input logic       wake_req,
  input logic       src_slow,
  input logic [1:0] sut_code,
  input logic       ready,
  input logic       code_err
);

  logic        any_req;
  logic        seen_req;
  logic [15:0] since_req;

  assign any_req = boot_req | wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_req  <= 1'b0;
      since_req <= '0;
    end else if (any_req) begin
      seen_req  <= 1'b1;
      since_req <= '0;
    end else if (since_req != 16'hFFFF) begin
      since_req <= since_req + 16'd1;
    end
  end

  // R7: a request pulls ready low on the next edge
  a_r7_req_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !ready);

  // R7: ready holds once up until a new request
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !any_req) |=> ready);

  // R6: reserved combination flags an error
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && src_slow && (sut_code == 2'd3)) |=> code_err);

  // R6: valid combination clears the error
  a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !(src_slow && (sut_code == 2'd3))) |=> !code_err);

  // R10: error flag changes only after a request
  a_r10_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> $stable(code_err));

  // R1: ready never rises before any request was taken
  a_r1_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> seen_req);

  // R4: no delay is shorter than the shortest cycle count
  a_r4_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (since_req >= 16'(MIN_GAP)));

endmodule

bind clk_startup_seq clk_startup_seq_checker #(.MIN_GAP(6)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .boot_req (boot_req),
  .wake_req (wake_req),
  .src_slow (src_slow),
  .sut_code (sut_code),
  .ready    (ready),
  .code_err (code_err)
);

// File: tb/clk_startup_seq_test.sv
module clk_startup_seq_test;

  localparam int TPM = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_req = 1'b0;
  logic       wake_req = 1'b0;
  logic       src_slow = 1'b0;
  logic [1:0] sut_code = 2'd0;
  logic       ms_tick = 1'b0;
  logic       ready;
  logic       code_err;

  int vectors = 0;
  int misses = 0;
  int cyc_idx = 0;
  string cur_req = "R1";

  // reference model state
  int   m_phase = 0;
  int   m_cnt = 0;
  int   m_tcnt = 0;
  int   m_c = 0;
  int   m_m = 0;
  logic m_ready = 1'b0;
  logic m_err = 1'b0;

  always #10 clk = ~clk;

  clk_startup_seq #(.TICKS_PER_MS(TPM)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_req (boot_req),
    .wake_req (wake_req),
    .src_slow (src_slow),
    .sut_code (sut_code),
    .ms_tick  (ms_tick),
    .ready    (ready),
    .code_err (code_err)
  );

  function automatic int exp_cycles(input logic s, input logic [1:0] c, input logic rst);
    if (rst) return 14;
    if (!s) return c[0] ? 16384 : 1024;
    return 6;
  endfunction

  function automatic int exp_ticks(input logic s, input logic [1:0] c, input logic rst);
    if (!rst) return 0;
    if (!s) return (c[1] ? 68 : 8) * TPM;
    case (c)
      2'd0: return 0;
      2'd1: return 4 * TPM;
      default: return 64 * TPM;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc_idx);
    end
  endtask

  task automatic model_edge();
    if (boot_req || wake_req) begin
      m_c = exp_cycles(src_slow, sut_code, boot_req);
      m_m = exp_ticks(src_slow, sut_code, boot_req);
      m_err = src_slow && (sut_code == 2'd3);
      m_phase = 1; m_cnt = 0; m_tcnt = 0; m_ready = 1'b0;
    end else if (m_phase == 1) begin
      m_cnt++;
      if (m_cnt == m_c) begin
        if (m_m == 0) begin m_phase = 3; m_ready = 1'b1; end
        else m_phase = 2;
      end
    end else if (m_phase == 2) begin
      if (ms_tick) begin
        m_tcnt++;
        if (m_tcnt == m_m) begin m_phase = 3; m_ready = 1'b1; end
      end
    end
  endtask

  task automatic step(input logic b, input logic w, input logic s, input logic [1:0] c);
    @(negedge clk);
    boot_req = b; wake_req = w; src_slow = s; sut_code = c;
    ms_tick = (cyc_idx % 3 == 0);
    cyc_idx++;
    model_edge();
    @(posedge clk);
    #5;
    check(cur_req, ready, m_ready, "ready");
    check(cur_req, code_err, m_err, "code_err");
  endtask

  // steps without request, scrambling config (R10); returns edges until ready
  task automatic run_to_ready(input int limit, output int n);
    n = 0;
    while (!m_ready && n < limit) begin
      step(1'b0, 1'b0, 1'($urandom % 2), 2'($urandom % 4));
      n++;
    end
  endtask

  task automatic directed_wake(input logic s, input logic [1:0] c, input string tag);
    int n;
    cur_req = tag;
    step(1'b0, 1'b1, s, c);
    run_to_ready(20000, n);
    vectors++;
    if (n != exp_cycles(s, c, 1'b0)) begin
      misses++;
      $display("FAIL %s wake length actual=%0d expected=%0d", tag, n, exp_cycles(s, c, 1'b0));
    end
    step(1'b0, 1'b0, s, c);
  endtask

  task automatic directed_boot(input logic s, input logic [1:0] c, input string tag);
    int n;
    cur_req = tag;
    step(1'b1, 1'b0, s, c);
    run_to_ready(20000, n);
    check(tag, ready, 1'b1, "ready_after_boot");
    step(1'b0, 1'b0, s, c);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'd1357));
    // R1: reset state
    repeat (3) @(posedge clk);
    #5;
    check("R1", ready, 1'b0, "ready_in_reset");
    check("R1", code_err, 1'b0, "err_in_reset");
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'($urandom % 2), 2'($urandom % 4));

    // R2: fast source wake lengths
    directed_wake(1'b0, 2'd0, "R2");
    directed_wake(1'b0, 2'd2, "R2");
    directed_wake(1'b0, 2'd1, "R2");
    directed_wake(1'b0, 2'd3, "R2");
    // R4: slow source wake lengths
    directed_wake(1'b1, 2'd0, "R4");
    directed_wake(1'b1, 2'd1, "R4");
    directed_wake(1'b1, 2'd2, "R4");
    // R6: reserved code, wake and reset
    directed_wake(1'b1, 2'd3, "R6");
    check("R6", code_err, 1'b1, "err_after_reserved");
    directed_boot(1'b1, 2'd3, "R6");
    // R3, R8: fast reset with ms portion
    for (int c = 0; c < 4; c++) directed_boot(1'b0, 2'(c), "R3");
    // R5: slow reset
    for (int c = 0; c < 3; c++) directed_boot(1'b1, 2'(c), "R5");
    check("R6", code_err, 1'b0, "err_cleared");

    // R8: ticks during cycle portion ignored (model counts only after it)
    cur_req = "R8";
    step(1'b1, 1'b0, 1'b1, 2'd1);
    run_to_ready(5000, n);
    check("R8", ready, 1'b1, "ready_after_tick_phase");

    // R9: restart mid-count and priority
    cur_req = "R9";
    step(1'b0, 1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 500; i++) step(1'b0, 1'b0, 1'b1, 2'd3);
    step(1'b0, 1'b1, 1'b1, 2'd0);
    run_to_ready(100, n);
    vectors++;
    if (n != 6) begin
      misses++;
      $display("FAIL R9 restart length actual=%0d expected=6", n);
    end
    step(1'b1, 1'b1, 1'b1, 2'd0);
    run_to_ready(100, n);
    vectors++;
    if (n != 14) begin
      misses++;
      $display("FAIL R9 priority length actual=%0d expected=14", n);
    end

    // R7, R9, R10: random requests with scrambled config
    cur_req = "R7";
    for (int k = 0; k < 40; k++) begin
      logic b = 1'($urandom % 2);
      logic s = 1'($urandom % 2);
      logic [1:0] c = 2'($urandom % 4);
      if (!b && !s) c[0] = 1'b0;
      step(b, !b || ($urandom % 4 == 0), s, c);
      if ($urandom % 3 == 0) begin
        for (int i = 0; i < int'($urandom % 40); i++)
          step(1'b0, 1'b0, 1'($urandom % 2), 2'($urandom % 4));
      end else begin
        run_to_ready(2000, n);
        for (int i = 0; i < 3; i++)
          step(1'b0, 1'b0, 1'($urandom % 2), 2'($urandom % 4));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule